// File: doc/BRIEF.md
# Predicate Register Compare Unit

This block keeps a bank of one-bit guard flags and refreshes them from compare operations. A compare request carries two operands, a compare code, a guard index and two destination indices. When the guard flag is true and the code is legal, the block evaluates the compare. It writes the outcome to the first destination and the inverted outcome to the second, so each compare yields a complementary pair of flags.

Two read ports serve issuing instructions. Each port returns the flag at the requested index, and the issue logic uses that value to decide whether an instruction commits. Flag 0 is hard-wired true, so an instruction guarded by it always takes effect.

The compare port is a valid/ready stream. `cmp_ready` is held high, so the port never applies back-pressure. A request is consumed on every rising clock edge at which `cmp_valid` is high, and its flag writes appear in storage after that edge. The read ports are plain combinational lookups with no handshake.

Top module: `pred_cmp_unit`

## Requirements
- R1: After reset, flags 1 to NUM_PRED-1 read 0 on both read ports, and flag 0 reads 1.
- R2: Index 0 always reads 1 on every read port. A compare that targets index 0 leaves it reading 1.
- R3: Signed compare codes are 0 = equal, 1 = not equal, 2 = less, 3 = less-or-equal, 4 = greater, 5 = greater-or-equal. They treat the operands as two's-complement numbers.
- R4: Unsigned compare codes are 6 = less, 7 = less-or-equal, 8 = greater, 9 = greater-or-equal. They treat the operands as unsigned numbers.
- R5: An accepted compare writes its outcome to `cmp_dst_t` and the inverted outcome to `cmp_dst_f`. Both values are visible on the read ports from the cycle after the accepting edge.
- R6: When `cmp_dst_t` equals `cmp_dst_f`, the outcome is written and the inverted write is dropped.
- R7: When the flag at `cmp_guard` reads 0, the compare leaves every flag unchanged.
- R8: Compare codes 10 to 15 write no flag.
- R9: A read of an index being written in the same cycle returns the new value (write-through).
- R10: `cmp_ready` is always 1. A cycle with `cmp_valid` low writes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_valid | input | 1 | Compare request present |
| cmp_ready | output | 1 | Compare request accepted (always 1) |
| cmp_a | input | 64 | First operand |
| cmp_b | input | 64 | Second operand |
| cmp_op | input | 4 | Compare code, 0 to 9 legal |
| cmp_guard | input | 6 | Index of the flag that qualifies the compare |
| cmp_dst_t | input | 6 | Destination for the outcome |
| cmp_dst_f | input | 6 | Destination for the inverted outcome |
| rd0_idx | input | 6 | Read port 0 index |
| rd0_val | output | 1 | Read port 0 flag value |
| rd1_idx | input | 6 | Read port 1 index |
| rd1_val | output | 1 | Read port 1 flag value |

## Verification
A compare writeback and a guard read can fall in the same cycle at the same index. The bench provokes this by holding a compare on the bus while both read ports point at its destinations, and samples the read ports before the clock edge. The values seen must already be the new pair, and they must be unchanged after the edge. A compare whose guard flag was set only by the previous compare also checks that the new value is used from the next cycle onward.

// File: rtl/pred_pkg.sv
package pred_pkg;
  localparam int OP_W = 4;
  localparam int NUM_OPS = 10;

  typedef enum logic [OP_W-1:0] {
    OP_EQ  = 4'd0,
    OP_NE  = 4'd1,
    OP_LT  = 4'd2,
    OP_LE  = 4'd3,
    OP_GT  = 4'd4,
    OP_GE  = 4'd5,
    OP_LTU = 4'd6,
    OP_LEU = 4'd7,
    OP_GTU = 4'd8,
    OP_GEU = 4'd9
  } cmp_op_e;
endpackage

// File: rtl/pred_cmp_eval.sv
module pred_cmp_eval
  import pred_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [OP_W-1:0]   op,
  output logic              res,
  output logic              legal
);
  logic eq, slt, ult;

  assign eq  = (a == b);
  assign slt = ($signed(a) < $signed(b));
  assign ult = (a < b);

  always_comb begin
    legal = 1'b1;
    res   = 1'b0;
    case (cmp_op_e'(op))
      OP_EQ:   res = eq;
      OP_NE:   res = !eq;
      OP_LT:   res = slt;
      OP_LE:   res = slt || eq;
      OP_GT:   res = !(slt || eq);
      OP_GE:   res = !slt;
      OP_LTU:  res = ult;
      OP_LEU:  res = ult || eq;
      OP_GTU:  res = !(ult || eq);
      OP_GEU:  res = !ult;
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/pred_file.sv
module pred_file #(
  parameter int NUM_PRED = 64,
  parameter int NUM_RD   = 2,
  localparam int IDX_W   = $clog2(NUM_PRED)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wt_en,
  input  logic [IDX_W-1:0] wt_idx,
  input  logic             wt_val,
  input  logic             wf_en,
  input  logic [IDX_W-1:0] wf_idx,
  input  logic             wf_val,
  input  logic [IDX_W-1:0] q_idx,
  output logic             q_val,
  input  logic [IDX_W-1:0] rd_idx [NUM_RD],
  output logic             rd_val [NUM_RD]
);
  logic [NUM_PRED-1:0] flags;

  assign flags[0] = 1'b0;

  for (genvar i = 1; i < NUM_PRED; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flags[i] <= 1'b0;
      else if (wt_en && wt_idx == IDX_W'(i))
        flags[i] <= wt_val;
      else if (wf_en && wf_idx == IDX_W'(i))
        flags[i] <= wf_val;
    end
  end

  // Guard lookup uses stored state only.
  assign q_val = (q_idx == '0) ? 1'b1 : flags[q_idx];

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    always_comb begin
      if (rd_idx[p] == '0)
        rd_val[p] = 1'b1;
      else if (wt_en && wt_idx == rd_idx[p])
        rd_val[p] = wt_val;
      else if (wf_en && wf_idx == rd_idx[p])
        rd_val[p] = wf_val;
      else
        rd_val[p] = flags[rd_idx[p]];
    end

    // R2: index zero is always true
    a_r2_zero_true: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx[p] == '0) |-> rd_val[p]);

    // R9: the bypassed value matches what storage holds after the edge
    a_r9_bypass_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (wt_en && wt_idx == rd_idx[p] && rd_idx[p] != '0)
        |=> (flags[$past(rd_idx[p])] == $past(rd_val[p])));
  end

  logic             pair_q;
  logic [IDX_W-1:0] pair_t_q, pair_f_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q   <= 1'b0;
      pair_t_q <= '0;
      pair_f_q <= '0;
    end else begin
      pair_q   <= wt_en && wf_en && (wt_idx != wf_idx);
      pair_t_q <= wt_idx;
      pair_f_q <= wf_idx;
    end
  end

  // R5: a paired write leaves complementary flags
  a_r5_dual_rail: assert property (@(posedge clk) disable iff (!rst_n)
    pair_q |-> (flags[pair_t_q] != flags[pair_f_q]));

  // R7: no write enable means storage holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wt_en && !wf_en) |=> $stable(flags));
endmodule

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit
  import pred_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NUM_PRED = 64,
  localparam int IDX_W   = $clog2(NUM_PRED)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  output logic              cmp_ready,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  input  logic [OP_W-1:0]   cmp_op,
  input  logic [IDX_W-1:0]  cmp_guard,
  input  logic [IDX_W-1:0]  cmp_dst_t,
  input  logic [IDX_W-1:0]  cmp_dst_f,
  input  logic [IDX_W-1:0]  rd0_idx,
  output logic              rd0_val,
  input  logic [IDX_W-1:0]  rd1_idx,
  output logic              rd1_val
);
  logic res, legal, guard_ok, fire, wt_en, wf_en;
  logic [IDX_W-1:0] rd_idx [2];
  logic             rd_val [2];

  assign cmp_ready = 1'b1;

  pred_cmp_eval #(.DATA_W(DATA_W)) u_eval (
    .a(cmp_a), .b(cmp_b), .op(cmp_op), .res(res), .legal(legal)
  );

  assign fire  = cmp_valid && guard_ok && legal;
  assign wt_en = fire && (cmp_dst_t != '0);
  assign wf_en = fire && (cmp_dst_f != '0) && (cmp_dst_f != cmp_dst_t);

  assign rd_idx[0] = rd0_idx;
  assign rd_idx[1] = rd1_idx;
  assign rd0_val   = rd_val[0];
  assign rd1_val   = rd_val[1];

  pred_file #(.NUM_PRED(NUM_PRED), .NUM_RD(2)) u_file (
    .clk(clk), .rst_n(rst_n),
    .wt_en(wt_en), .wt_idx(cmp_dst_t), .wt_val(res),
    .wf_en(wf_en), .wf_idx(cmp_dst_f), .wf_val(!res),
    .q_idx(cmp_guard), .q_val(guard_ok),
    .rd_idx(rd_idx), .rd_val(rd_val)
  );

  // R8: illegal codes never reach the writeback
  a_r8_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_op >= OP_W'(NUM_OPS)) |-> !(wt_en || wf_en));

  // R10: idle request port writes nothing
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |-> !(wt_en || wf_en));

  // R6: same destination drops the inverted write
  a_r6_same_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_dst_t == cmp_dst_f) |-> !wf_en);
endmodule

// File: tb/tb_pred_cmp_unit.sv
module tb_pred_cmp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 1'b0;
  logic        cmp_ready;
  logic [63:0] cmp_a = '0, cmp_b = '0;
  logic [3:0]  cmp_op = '0;
  logic [5:0]  cmp_guard = '0, cmp_dst_t = '0, cmp_dst_f = '0;
  logic [5:0]  rd0_idx = '0, rd1_idx = '0;
  logic        rd0_val, rd1_val;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  pred_cmp_unit dut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] i0, input logic e0,
                        input logic [5:0] i1, input logic e1);
    @(negedge clk);
    rd0_idx = i0; rd1_idx = i1;
    #1;
    chk(tag, rd0_val, e0);
    chk(tag, rd1_val, e1);
  endtask

  task automatic do_cmp(input logic [63:0] a, input logic [63:0] b, input logic [3:0] op,
                        input logic [5:0] g, input logic [5:0] t, input logic [5:0] f);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_a = a; cmp_b = b; cmp_op = op;
    cmp_guard = g; cmp_dst_t = t; cmp_dst_f = f;
    @(posedge clk);
    #1 cmp_valid = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1 reset", 6'd1, 1'b0, 6'd63, 1'b0);
    rd_chk("R1 reset p0", 6'd0, 1'b1, 6'd30, 1'b0);
    chk("R10 ready", cmp_ready, 1'b1);
  endtask

  task automatic t_ops();
    logic [9:0] exp_neg = 10'b1100001110; // a=-1, b=1
    logic [9:0] exp_eq  = 10'b1010101001; // a=b=5
    for (int k = 0; k < 10; k++) begin
      do_cmp(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 4'(k), 6'd0, 6'd10, 6'd11);
      rd_chk(k < 6 ? "R3 signed neg" : "R4 unsigned neg", 6'd10, exp_neg[k], 6'd11, !exp_neg[k]);
      do_cmp(64'd5, 64'd5, 4'(k), 6'd0, 6'd10, 6'd11);
      rd_chk(k < 6 ? "R3 signed eq R5" : "R4 unsigned eq R5", 6'd10, exp_eq[k], 6'd11, !exp_eq[k]);
    end
  endtask

  task automatic t_zero_dst();
    do_cmp(64'd1, 64'd2, 4'd0, 6'd0, 6'd0, 6'd20); // outcome 0
    rd_chk("R2 p0 write ignored", 6'd0, 1'b1, 6'd20, 1'b1);
  endtask

  task automatic t_same_dst();
    do_cmp(64'd3, 64'd3, 4'd0, 6'd0, 6'd21, 6'd21); // outcome 1
    rd_chk("R6 same dst", 6'd21, 1'b1, 6'd22, 1'b0);
  endtask

  task automatic t_guard();
    // 10/11 hold 1/0 from the last eq compare of code 9 (geu true)
    do_cmp(64'd1, 64'd2, 4'd0, 6'd12, 6'd10, 6'd11);
    rd_chk("R7 guard false", 6'd10, 1'b1, 6'd11, 1'b0);
    do_cmp(64'd7, 64'd7, 4'd0, 6'd0, 6'd12, 6'd13);
    do_cmp(64'd1, 64'd2, 4'd0, 6'd12, 6'd10, 6'd11);
    rd_chk("R7 guard true", 6'd10, 1'b0, 6'd11, 1'b1);
  endtask

  task automatic t_bad_code();
    do_cmp(64'd4, 64'd4, 4'd12, 6'd0, 6'd10, 6'd11);
    rd_chk("R8 code 12", 6'd10, 1'b0, 6'd11, 1'b1);
    do_cmp(64'd4, 64'd4, 4'd15, 6'd0, 6'd10, 6'd11);
    rd_chk("R8 code 15", 6'd10, 1'b0, 6'd11, 1'b1);
  endtask

  task automatic t_idle();
    @(negedge clk);
    cmp_valid = 1'b0; cmp_a = 64'd9; cmp_b = 64'd9; cmp_op = 4'd0;
    cmp_guard = 6'd0; cmp_dst_t = 6'd10; cmp_dst_f = 6'd11;
    @(posedge clk);
    rd_chk("R10 valid low", 6'd10, 1'b0, 6'd11, 1'b1);
  endtask

  task automatic t_bypass();
    @(negedge clk);
    cmp_valid = 1'b1; cmp_a = 64'd8; cmp_b = 64'd8; cmp_op = 4'd0;
    cmp_guard = 6'd0; cmp_dst_t = 6'd40; cmp_dst_f = 6'd41;
    rd0_idx = 6'd40; rd1_idx = 6'd41;
    #1;
    chk("R9 bypass t", rd0_val, 1'b1);
    chk("R9 bypass f", rd1_val, 1'b0);
    @(posedge clk);
    #1 cmp_valid = 1'b0;
    rd_chk("R9 after edge", 6'd40, 1'b1, 6'd41, 1'b0);
  endtask

  initial begin
    fork
      begin
        #20 rst_n = 1'b1;
        t_reset();
        t_ops();
        t_zero_dst();
        t_same_dst();
        t_guard();
        t_bad_code();
        t_idle();
        t_bypass();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule